// File: doc/BRIEF.md
# Read-Path Nibble Rotate Unit

This unit sits between a processor's data-memory port and the data RAM. One reserved word address acts as a shifter. A value is written there as usual, and a later read of that word returns it transformed. A 2-bit mode input picks the transform: plain, rotated four bits left, rotated four bits right, or with its two bytes swapped. Firmware can therefore shift a word by a nibble or a byte without a shift instruction, using one store and one load.

Writes go to the RAM untouched, so the stored word is always the raw value. Reads of any other address come back unchanged whatever the mode. The RAM has a synchronous read with a latency of `RD_LAT` cycles. The unit registers, at the read strobe, whether the reserved word was read and which mode was in force. When the RAM data returns, it applies the transform combinationally in the same cycle, so a read costs no extra cycle.

Top module: `nibble_rotate_unit`

## Requirements
- R1: While `rst` is high, and in the cycles after it falls until a new read strobe has completed, `cpu_rdata` equals `ram_rdata`. A read strobe to the reserved word that was in flight during reset is never transformed.
- R2: With mode 2'b00, a read of the reserved word (default address 10'h1FE) returns the RAM word unchanged.
- R3: With mode 2'b01, a read of the reserved word returns the RAM word rotated left by 4 bits. Bits [11:0] move to [15:4] and bits [15:12] move to [3:0].
- R4: With mode 2'b10, a read of the reserved word returns the RAM word rotated right by 4 bits. A stored 16'h3ED7 reads back as 16'h73ED.
- R5: With mode 2'b11, a read of the reserved word returns the RAM word with bytes [15:8] and [7:0] exchanged.
- R6: A read of any address other than the reserved word returns `ram_rdata` unchanged in every mode.
- R7: `ram_wdata` always equals `cpu_wdata`, so the RAM stores the raw value. A strobe with `cpu_wr` high is a write even if `cpu_rd` is also high, and its returned data is never transformed.
- R8: The transformed word appears on `cpu_rdata` in the same cycle that `ram_rdata` returns, `RD_LAT` cycles after the read strobe.
- R9: The mode used is the one present at the read strobe. A change of `xform_mode` while the data is returning does not alter the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | AW (10) | Word address of the access |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe |
| cpu_wdata | input | DW (16) | Write data from the processor |
| xform_mode | input | 2 | Transform select: 00 plain, 01 rotate left 4, 10 rotate right 4, 11 byte swap |
| ram_wdata | output | DW (16) | Write data to the RAM, always raw |
| ram_rdata | input | DW (16) | Read data returned by the RAM |
| cpu_rdata | output | DW (16) | Read data to the processor, transformed when required |

## Verification
The bench sweeps every mode across many data patterns at the reserved word and at neighbouring addresses that differ by a single address bit. A decoder that compared too few address bits would transform those neighbours. A design with the rotate directions swapped would return 16'hED73 for 16'h3ED7 instead of 16'h73ED. The bench changes the mode during every return cycle. A design that read the live mode instead of the mode captured at the strobe would then give the wrong transform. It also reads the reserved word back in plain mode after writing it under a rotate mode, and issues combined read-write strobes and a reset while a read is in flight. A design that transformed on the write path, or that kept a stale tag through reset, would return a rotated word in those cases.

// File: rtl/nibble_rotate_pkg.sv
package nibble_rotate_pkg;

  typedef enum logic [1:0] {
    XM_PLAIN = 2'b00,
    XM_ROTL  = 2'b01,
    XM_ROTR  = 2'b10,
    XM_SWAP  = 2'b11
  } xmode_e;

  typedef struct packed {
    logic   hit;
    xmode_e mode;
  } xtag_t;

endpackage

// File: rtl/nr_addr_match.sv
module nr_addr_match #(
  parameter int AW = 10,
  parameter logic [AW-1:0] SHIFT_ADDR = 10'h1FE
) (
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  output logic          hit
);

  // A combined strobe counts as a write, so its data is never transformed
  assign hit = rd && !wr && (addr == SHIFT_ADDR);

endmodule

// File: rtl/nr_tag_pipe.sv
module nr_tag_pipe
  import nibble_rotate_pkg::*;
#(
  parameter int RD_LAT = 1
) (
  input  logic   clk,
  input  logic   rst,
  input  xtag_t  tag_in,
  output xtag_t  tag_out
);

  localparam xtag_t TAG_IDLE = '{hit: 1'b0, mode: XM_PLAIN};

  xtag_t stage [RD_LAT];

  generate
    for (genvar s = 0; s < RD_LAT; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[s] <= TAG_IDLE;
          else     stage[s] <= tag_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[s] <= TAG_IDLE;
          else     stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign tag_out = stage[RD_LAT-1];

endmodule

// File: rtl/nr_datapath.sv
module nr_datapath
  import nibble_rotate_pkg::*;
#(
  parameter int DW  = 16,
  parameter int ROT = 4
) (
  input  xtag_t         tag,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);

  localparam int HALF = DW / 2;

  logic [DW-1:0] rot_l, rot_r, swapped;

  assign rot_l   = {din[DW-ROT-1:0], din[DW-1:DW-ROT]};
  assign rot_r   = {din[ROT-1:0], din[DW-1:ROT]};
  assign swapped = {din[HALF-1:0], din[DW-1:HALF]};

  always_comb begin
    dout = din;
    if (tag.hit) begin
      unique case (tag.mode)
        XM_PLAIN: dout = din;
        XM_ROTL:  dout = rot_l;
        XM_ROTR:  dout = rot_r;
        XM_SWAP:  dout = swapped;
        default:  dout = din;
      endcase
    end
  end

endmodule

// File: rtl/nibble_rotate_unit.sv
module nibble_rotate_unit
  import nibble_rotate_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 16,
  parameter int ROT = 4,
  parameter int RD_LAT = 1,
  parameter logic [AW-1:0] SHIFT_ADDR = 10'h1FE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic [DW-1:0] cpu_wdata,
  input  logic [1:0]    xform_mode,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata,
  output logic [DW-1:0] cpu_rdata
);

  logic  req_hit;
  xtag_t req_tag;
  xtag_t ret_tag;

  nr_addr_match #(.AW(AW), .SHIFT_ADDR(SHIFT_ADDR)) u_match (
    .addr (cpu_addr),
    .rd   (cpu_rd),
    .wr   (cpu_wr),
    .hit  (req_hit)
  );

  assign req_tag.hit  = req_hit;
  assign req_tag.mode = xmode_e'(xform_mode);

  nr_tag_pipe #(.RD_LAT(RD_LAT)) u_pipe (
    .clk     (clk),
    .rst     (rst),
    .tag_in  (req_tag),
    .tag_out (ret_tag)
  );

  nr_datapath #(.DW(DW), .ROT(ROT)) u_dp (
    .tag  (ret_tag),
    .din  (ram_rdata),
    .dout (cpu_rdata)
  );

  assign ram_wdata = cpu_wdata;

endmodule

// File: rtl/nibble_rotate_unit_chk.sv
module nibble_rotate_unit_chk #(
  parameter int AW = 10,
  parameter int DW = 16,
  parameter int ROT = 4,
  parameter int RD_LAT = 1,
  parameter logic [AW-1:0] SHIFT_ADDR = 10'h1FE
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] cpu_addr,
  input logic          cpu_wr,
  input logic          cpu_rd,
  input logic [1:0]    xform_mode,
  input logic [DW-1:0] ram_rdata,
  input logic [DW-1:0] cpu_rdata
);

  localparam int HALF = DW / 2;

  logic       sp_q [RD_LAT];
  logic       ot_q [RD_LAT];
  logic [1:0] md_q [RD_LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < RD_LAT; i++) begin
        sp_q[i] <= 1'b0;
        ot_q[i] <= 1'b0;
        md_q[i] <= 2'b00;
      end
    end else begin
      for (int i = RD_LAT - 1; i > 0; i--) begin
        sp_q[i] <= sp_q[i-1];
        ot_q[i] <= ot_q[i-1];
        md_q[i] <= md_q[i-1];
      end
      sp_q[0] <= cpu_rd && !cpu_wr && cpu_addr == SHIFT_ADDR;
      ot_q[0] <= (cpu_rd || cpu_wr) && !(cpu_rd && !cpu_wr && cpu_addr == SHIFT_ADDR);
      md_q[0] <= xform_mode;
    end
  end

  logic       sp_ret, ot_ret;
  logic [1:0] md_ret;
  assign sp_ret = sp_q[RD_LAT-1];
  assign ot_ret = ot_q[RD_LAT-1];
  assign md_ret = md_q[RD_LAT-1];

  a_r1_reset_plain: assert property (@(posedge clk) rst |=> cpu_rdata == ram_rdata);

  a_r2_plain: assert property (@(posedge clk) disable iff (rst)
    (sp_ret && md_ret == 2'b00) |-> cpu_rdata == ram_rdata);

  a_r3_rotl: assert property (@(posedge clk) disable iff (rst)
    (sp_ret && md_ret == 2'b01) |-> cpu_rdata == {ram_rdata[DW-ROT-1:0], ram_rdata[DW-1:DW-ROT]});

  a_r4_rotr: assert property (@(posedge clk) disable iff (rst)
    (sp_ret && md_ret == 2'b10) |-> cpu_rdata == {ram_rdata[ROT-1:0], ram_rdata[DW-1:ROT]});

  a_r5_swap: assert property (@(posedge clk) disable iff (rst)
    (sp_ret && md_ret == 2'b11) |-> cpu_rdata == {ram_rdata[HALF-1:0], ram_rdata[DW-1:HALF]});

  a_r6_r7_untouched: assert property (@(posedge clk) disable iff (rst)
    ot_ret |-> cpu_rdata == ram_rdata);

endmodule

bind nibble_rotate_unit nibble_rotate_unit_chk #(
  .AW(AW), .DW(DW), .ROT(ROT), .RD_LAT(RD_LAT), .SHIFT_ADDR(SHIFT_ADDR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_addr   (cpu_addr),
  .cpu_wr     (cpu_wr),
  .cpu_rd     (cpu_rd),
  .xform_mode (xform_mode),
  .ram_rdata  (ram_rdata),
  .cpu_rdata  (cpu_rdata)
);

// File: tb/sim_nibble_rotate_unit.sv
module sim_nibble_rotate_unit;

  localparam int AW = 10;
  localparam int DW = 16;
  localparam logic [AW-1:0] SP = 10'h1FE;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_wr = 1'b0;
  logic          cpu_rd = 1'b0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [1:0]    xform_mode = 2'b00;
  logic [DW-1:0] ram_wdata;
  logic [DW-1:0] ram_rdata = '0;
  logic [DW-1:0] cpu_rdata;

  logic [DW-1:0] mem [1024];

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  nibble_rotate_unit u0 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .xform_mode(xform_mode), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .cpu_rdata(cpu_rdata)
  );

  // Bench RAM: one-cycle synchronous read, write has priority on a combined strobe
  always @(posedge clk) begin
    if (cpu_wr) mem[cpu_addr] <= ram_wdata;
    else if (cpu_rd) ram_rdata <= mem[cpu_addr];
  end

  function automatic logic [15:0] expect_of(input logic [1:0] m, input logic [15:0] d);
    int v;
    v = int'(d);
    case (m)
      2'b01:   return 16'(((v << 4) | (v >> 12)) & 32'hFFFF);
      2'b10:   return 16'(((v >> 4) | (v << 12)) & 32'hFFFF);
      2'b11:   return 16'(((v >> 8) | (v << 8)) & 32'hFFFF);
      default: return d;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] m);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0; xform_mode = m;
    #1 check("R7 raw write data", ram_wdata, d);
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  // Read strobe, then flip the mode in the return cycle (R9) and sample there (R8)
  task automatic do_read(input logic [AW-1:0] a, input logic [1:0] m, input string req,
                         input logic [15:0] exp);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0; xform_mode = m;
    @(negedge clk);
    cpu_rd = 1'b0; xform_mode = ~m;
    #1 check(req, cpu_rdata, exp);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [AW-1:0] nbr [5];
    nbr[0] = SP ^ 10'h001; nbr[1] = SP ^ 10'h002; nbr[2] = SP ^ 10'h100;
    nbr[3] = SP ^ 10'h200; nbr[4] = 10'h000;
    for (int i = 0; i < 1024; i++) mem[i] = 16'(i * 16'h9E37);

    repeat (3) @(negedge clk);
    #1 check("R1 reset output", cpu_rdata, ram_rdata);
    rst = 1'b0;

    // R4 stated example
    do_write(SP, 16'h3ED7, 2'b10);
    do_read(SP, 2'b10, "R4 rotr 3ED7", 16'h73ED);
    check("R7 stored raw", mem[SP], 16'h3ED7);
    do_read(SP, 2'b00, "R2 plain readback", 16'h3ED7);

    // Sweep: every mode, many patterns, reserved word and single-bit neighbours
    for (int p = 0; p < 64; p++) begin
      logic [15:0] d;
      d = 16'((p * 16'h1357) ^ (p << 9) ^ 16'hA5C3);
      for (int m = 0; m < 4; m++) begin
        do_write(SP, d, 2'(m));
        case (m)
          0: do_read(SP, 2'(m), "R2 plain", expect_of(2'(m), d));
          1: do_read(SP, 2'(m), "R3 rotl", expect_of(2'(m), d));
          2: do_read(SP, 2'(m), "R4 rotr", expect_of(2'(m), d));
          default: do_read(SP, 2'(m), "R5 swap", expect_of(2'(m), d));
        endcase
        check("R7 stored raw", mem[SP], d);
        do_write(nbr[p % 5], ~d, 2'(m));
        do_read(nbr[p % 5], 2'(m), "R6 other address", ~d);
      end
    end

    // R7: combined read-write strobe to the reserved word is not transformed
    do_write(SP, 16'h1234, 2'b01);
    @(negedge clk);
    cpu_addr = SP; cpu_rd = 1'b1; cpu_wr = 1'b1; cpu_wdata = 16'hBEEF; xform_mode = 2'b01;
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    #1 check("R7 combined strobe no transform", cpu_rdata, ram_rdata);
    check("R7 combined strobe stored raw", mem[SP], 16'hBEEF);

    // R9: mode flipped mid-return must not alter results (also exercised in sweep)
    do_write(SP, 16'hF00D, 2'b11);
    do_read(SP, 2'b11, "R9 sampled mode swap", 16'h0DF0);

    // R1: reset while a read of the reserved word is in flight
    do_write(SP, 16'h4321, 2'b01);
    @(negedge clk);
    cpu_addr = SP; cpu_rd = 1'b1; xform_mode = 2'b01; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; cpu_rd = 1'b0;
    #1 check("R1 in-flight read after reset", cpu_rdata, 16'h4321);

    summary();
  end

endmodule